// File: doc/BRIEF.md
# Power Mode Controller

This block moves a microcontroller-class device between four power modes: Active, Power Save, Idle and Halt. Software loads a small control register that holds mode requests, an oscillator-disable choice and a flag that makes entry wait for the CPU's wait instruction. The block then commits the change when the wait strobe arrives, or at once for a plain Power Save request. Each transition is held back until the clock that the target mode needs reports stable. Entry to Power Save or Idle needs the low-frequency clock. A return to Active needs the high-frequency oscillator first and then the PLL.

A non-maskable interrupt or a multi-input wake-up event returns the device to Active from any low-power mode through a fixed sequence. The sequence enables the oscillator and waits for it to settle, then enables the PLL and waits for it to lock. Only then does the mode become Active. A software exit from Power Save goes through the same sequence. The block drives the oscillator enable (which also gates the main clock), the PLL enable and the slow-clock select. The oscillators, the PLL and the glitch-free clock multiplexer are outside this block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode is Active (`mode`=0), `hf_osc_en`=1, `pll_en`=1, `slow_clk_sel`=0 and `ctl_rd`=0.
- R2: Idle (`mode`=2) is entered when the idle request bit (`wr_data[1]`) is set and `wait_strobe` is asserted. From Active this also needs the wait-gate bit (`wr_data[4]`); without that bit the strobe is ignored. From Power Save the wait-gate bit is not needed.
- R3: Halt (`mode`=3) is entered the same way through the halt request bit (`wr_data[2]`). In Halt `hf_osc_en` and `pll_en` are 0, whatever the disable bit holds.
- R4: Power Save (`mode`=1) is requested through `wr_data[0]`. With the wait-gate bit clear it is entered without a strobe; with the bit set it waits for `wait_strobe`. While a low-frequency crystal is present and `lf_stable` is 0, entry is held off.
- R5: `hf_osc_en` is 1 in Active. In Power Save and Idle, with a crystal present, it equals the inverse of the disable bit (`wr_data[3]`). This takes effect one cycle after the write, or on the edge that enters the mode. `slow_clk_sel` is 1 in every mode other than Active.
- R6: With `lf_xtal_present`=0 the slow clock comes from the main clock. `hf_osc_en` then stays 1 in Power Save and Idle even when the disable bit is set, and entry to those modes needs no `lf_stable`.
- R7: A pulse on `nmi` or `wake_line` in Power Save, Idle or Halt starts the wake sequence. `hf_osc_en` goes to 1 at once. `pll_en` rises only after `hf_stable` has been seen. `mode` keeps the source mode until `pll_stable` is seen, and then becomes Active.
- R8: Writing 0 to `wr_data[0]` in Power Save leaves through the same sequence. `ctl_rd[0]` reads 1 exactly while `mode` reports Power Save, so it drops only once Active is reached.
- R9: A strobe with no request bit set, a strobe in Idle or Halt, and a halt request in Idle are all ignored: the mode does not change.
- R10: The idle and halt request bits (`ctl_rd[1]`, `ctl_rd[2]`) clear on the edge that enters that mode. All request bits clear on the edge that reaches Active after a wake. `ctl_rd[3]` and `ctl_rd[4]` keep their written values.
- R11: With several requests pending in Active, Halt wins over Idle and Idle wins over Power Save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Loads `wr_data` into the control register |
| wr_data | input | 5 | {wait-gate, hf-disable, halt req, idle req, save req} |
| wait_strobe | input | 1 | One-cycle pulse from the CPU wait instruction |
| nmi | input | 1 | Non-maskable interrupt wake request |
| wake_line | input | 1 | Validated multi-input wake-up event |
| lf_xtal_present | input | 1 | 1 when a low-frequency crystal is fitted |
| lf_stable | input | 1 | Low-frequency clock stable status |
| hf_stable | input | 1 | High-frequency oscillator stable status |
| pll_stable | input | 1 | PLL lock status (reads 1 while the PLL is off) |
| mode | output | 2 | 0 Active, 1 Power Save, 2 Idle, 3 Halt |
| hf_osc_en | output | 1 | High-frequency oscillator and main clock enable |
| pll_en | output | 1 | PLL enable |
| slow_clk_sel | output | 1 | 1 selects the slow system clock |
| ctl_rd | output | 5 | Register readback; bit 0 is the in-Power-Save flag |

## Verification
The bench targets the stall cases. It holds `lf_stable` low against a Power Save request, which a design without the clock gate would enter early. It also wakes from Halt with the oscillator cold: a sequencer that enabled the PLL at the same time as the oscillator, or trusted the PLL status read while the PLL was off, would reach Active before lock. It checks the illegal and ungated strobes, where a design that decoded them would fall into Idle or Halt. It also checks the Power Save readback during a software exit, which a design that mirrored the written bit would drop too soon. The crystal-less case tests that the oscillator stays on in Idle despite the disable bit.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  localparam int CTL_W  = 5;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ACT  = 2'd0,
    MODE_SAVE = 2'd1,
    MODE_IDLE = 2'd2,
    MODE_HALT = 2'd3
  } pmode_t;

  typedef enum logic [2:0] {
    ST_ACT, ST_SAVE, ST_IDLE, ST_HALT, ST_WHF, ST_WPLL0, ST_WPLL
  } pstate_t;

  // bit 0 is save request, bit 4 is the wait gate
  typedef struct packed {
    logic wbps;
    logic dhf;
    logic halt;
    logic idle;
    logic save;
  } ctl_t;
endpackage

// File: rtl/pmm_ctlreg.sv
module pmm_ctlreg
  import pmm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             clr_entry,
  input  logic             clr_wake,
  output ctl_t             ctl
);
  // a software write in the same cycle takes priority over auto-clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl <= ctl_t'(wr_data);
    end else begin
      if (clr_entry) begin
        ctl.idle <= 1'b0;
        ctl.halt <= 1'b0;
      end
      if (clr_wake) begin
        ctl.save <= 1'b0;
        ctl.idle <= 1'b0;
        ctl.halt <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pmm_fsm.sv
module pmm_fsm
  import pmm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ctl_t   ctl,
  input  logic   wait_strobe,
  input  logic   wake_req,
  input  logic   hf_stable,
  input  logic   pll_stable,
  input  logic   lf_stable,
  input  logic   lf_xtal,
  output pmode_t mode_o,
  output logic   hf_en_o,
  output logic   pll_en_o,
  output logic   slow_sel_o,
  output logic   save_flag_o,
  output logic   clr_entry,
  output logic   clr_wake
);
  pstate_t st_q, nxt;
  pmode_t  src_q, src_d, mode_nxt;
  logic    pend_q, pend_d, arm, lf_ok, waking;
  logic    hf_nxt, pll_nxt;

  function automatic pmode_t rest_mode(input pstate_t s);
    case (s)
      ST_SAVE: return MODE_SAVE;
      ST_IDLE: return MODE_IDLE;
      ST_HALT: return MODE_HALT;
      default: return MODE_ACT;
    endcase
  endfunction

  assign lf_ok = lf_stable | ~lf_xtal;
  assign arm   = wait_strobe | pend_q;

  always_comb begin
    nxt   = st_q;
    src_d = src_q;
    case (st_q)
      ST_ACT: begin
        if (ctl.halt) begin
          if (ctl.wbps && arm) nxt = ST_HALT;
        end else if (ctl.idle) begin
          if (ctl.wbps && arm && lf_ok) nxt = ST_IDLE;
        end else if (ctl.save) begin
          if ((!ctl.wbps || arm) && lf_ok) nxt = ST_SAVE;
        end
      end
      ST_SAVE: begin
        if (wake_req)                              nxt = ST_WHF;
        else if (wait_strobe && ctl.halt)          nxt = ST_HALT;
        else if (wait_strobe && ctl.idle && lf_ok) nxt = ST_IDLE;
        else if (!ctl.save)                        nxt = ST_WHF;
      end
      ST_IDLE, ST_HALT: if (wake_req) nxt = ST_WHF;
      ST_WHF:   if (hf_stable)  nxt = ST_WPLL0;
      ST_WPLL0: nxt = ST_WPLL;
      ST_WPLL:  if (pll_stable) nxt = ST_ACT;
      default:  nxt = ST_ACT;
    endcase
    if (nxt == ST_WHF && st_q != ST_WHF) src_d = rest_mode(st_q);
  end

  assign waking   = (nxt == ST_WHF) || (nxt == ST_WPLL0) || (nxt == ST_WPLL);
  assign mode_nxt = waking ? src_d : rest_mode(nxt);
  assign pend_d   = (st_q == ST_ACT) && (nxt == ST_ACT) && ctl.wbps &&
                    (ctl.halt | ctl.idle | ctl.save) && arm;

  always_comb begin
    case (nxt)
      ST_HALT:          hf_nxt = 1'b0;
      ST_SAVE, ST_IDLE: hf_nxt = ~ctl.dhf | ~lf_xtal;
      default:          hf_nxt = 1'b1;
    endcase
  end
  assign pll_nxt = (nxt == ST_ACT) || (nxt == ST_WPLL0) || (nxt == ST_WPLL);

  assign clr_entry = ((nxt == ST_IDLE) && (st_q != ST_IDLE)) ||
                     ((nxt == ST_HALT) && (st_q != ST_HALT));
  assign clr_wake  = (st_q == ST_WPLL) && (nxt == ST_ACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_ACT;
      src_q       <= MODE_ACT;
      pend_q      <= 1'b0;
      mode_o      <= MODE_ACT;
      hf_en_o     <= 1'b1;
      pll_en_o    <= 1'b1;
      slow_sel_o  <= 1'b0;
      save_flag_o <= 1'b0;
    end else begin
      st_q        <= nxt;
      src_q       <= src_d;
      pend_q      <= pend_d;
      mode_o      <= mode_nxt;
      hf_en_o     <= hf_nxt;
      pll_en_o    <= pll_nxt;
      slow_sel_o  <= (nxt != ST_ACT);
      save_flag_o <= (mode_nxt == MODE_SAVE);
    end
  end

  // R5
  act_clocks_on_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_ACT) |-> (hf_en_o && pll_en_o && !slow_sel_o));

  // R3
  halt_hf_off_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT) |-> (!hf_en_o && !pll_en_o));

  // R7
  act_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_ACT && $past(mode_o) != MODE_ACT) |-> ($past(pll_stable) && $past(hf_stable)));

  // R7
  pll_after_hf_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en_o) |-> $past(hf_stable));

  // R4
  save_needs_lf_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_SAVE && $past(mode_o) == MODE_ACT) |-> $past(lf_stable || !lf_xtal));

  // R9
  no_halt_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_IDLE) |-> ($past(mode_o) != MODE_HALT));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic              wait_strobe,
  input  logic              nmi,
  input  logic              wake_line,
  input  logic              lf_xtal_present,
  input  logic              lf_stable,
  input  logic              hf_stable,
  input  logic              pll_stable,
  output logic [MODE_W-1:0] mode,
  output logic              hf_osc_en,
  output logic              pll_en,
  output logic              slow_clk_sel,
  output logic [CTL_W-1:0]  ctl_rd
);
  ctl_t   ctl;
  pmode_t mode_q;
  logic   clr_entry, clr_wake, save_flag;

  pmm_ctlreg u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .clr_entry (clr_entry),
    .clr_wake  (clr_wake),
    .ctl       (ctl)
  );

  pmm_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .wait_strobe (wait_strobe),
    .wake_req    (nmi | wake_line),
    .hf_stable   (hf_stable),
    .pll_stable  (pll_stable),
    .lf_stable   (lf_stable),
    .lf_xtal     (lf_xtal_present),
    .mode_o      (mode_q),
    .hf_en_o     (hf_osc_en),
    .pll_en_o    (pll_en),
    .slow_sel_o  (slow_clk_sel),
    .save_flag_o (save_flag),
    .clr_entry   (clr_entry),
    .clr_wake    (clr_wake)
  );

  assign mode   = mode_q;
  assign ctl_rd = {ctl.wbps, ctl.dhf, ctl.halt, ctl.idle, save_flag};
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int HF_LAT  = 4;
  localparam int PLL_LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wait_strobe = 1'b0, nmi = 1'b0, wake_line = 1'b0;
  logic [4:0] wr_data = '0;
  logic lf_xtal_present = 1'b1, lf_stable = 1'b1;
  logic hf_stable, pll_stable;
  logic [1:0] mode;
  logic hf_osc_en, pll_en, slow_clk_sel;
  logic [4:0] ctl_rd;
  int hf_cnt = 0, pll_cnt = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wait_strobe(wait_strobe), .nmi(nmi), .wake_line(wake_line),
    .lf_xtal_present(lf_xtal_present), .lf_stable(lf_stable),
    .hf_stable(hf_stable), .pll_stable(pll_stable),
    .mode(mode), .hf_osc_en(hf_osc_en), .pll_en(pll_en),
    .slow_clk_sel(slow_clk_sel), .ctl_rd(ctl_rd)
  );

  // oscillator and PLL models: settle a fixed time after enable
  always @(posedge clk) begin
    hf_cnt  <= (!hf_osc_en) ? 0 : (hf_cnt  < HF_LAT  ? hf_cnt + 1  : hf_cnt);
    pll_cnt <= (!pll_en)    ? 0 : (pll_cnt < PLL_LAT ? pll_cnt + 1 : pll_cnt);
  end
  assign hf_stable  = (hf_cnt == HF_LAT);
  assign pll_stable = !pll_en || (pll_cnt == PLL_LAT);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    wait_strobe = 1'b1;
    @(negedge clk);
    wait_strobe = 1'b0;
  endtask

  task automatic pulse_nmi();
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
  endtask

  // R7: follow a wake sequence to Active, checking ordering each cycle
  task automatic wait_act(logic [1:0] src);
    for (int i = 0; i < 60; i++) begin
      if (mode == 2'd0) break;
      chk("R7 source mode held", mode, src);
      chk("R7 hf enabled first", hf_osc_en, 1);
      if (pll_en) chk("R7 pll only after hf stable", hf_stable, 1);
      @(negedge clk);
    end
    chk("R7 reached active", mode, 0);
  endtask

  // {wr, wdata[4:0], strobe, wake, exp_mode[1:0], exp_hf, exp_pll, exp_slow, exp_rd[4:0]}
  localparam logic [17:0] VEC [8] = '{
    18'b1_00000_1_0_00_1_1_0_00000,
    18'b1_00010_0_0_00_1_1_0_00010,
    18'b0_00000_1_0_00_1_1_0_00010,
    18'b1_10010_0_0_00_1_1_0_10010,
    18'b0_00000_1_0_10_1_0_1_10000,
    18'b1_10100_0_0_10_1_0_1_10100,
    18'b0_00000_1_0_10_1_0_1_10100,
    18'b0_00000_0_1_10_1_0_1_10100
  };
  string vtag [8] = '{"R9 bare strobe", "R2 idle req written", "R2 strobe without gate",
                      "R2 gate written", "R2 R10 idle entry", "R9 halt req in idle",
                      "R9 halt strobe in idle", "R7 wake start"};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1
    chk("R1 mode", mode, 0);
    chk("R1 hf", hf_osc_en, 1);
    chk("R1 pll", pll_en, 1);
    chk("R1 slow", slow_clk_sel, 0);
    chk("R1 rd", ctl_rd, 0);
    cyc(6);

    for (int i = 0; i < 8; i++) begin
      wr_en = VEC[i][17]; wr_data = VEC[i][16:12];
      wait_strobe = VEC[i][11]; nmi = VEC[i][10];
      @(negedge clk);
      wr_en = 1'b0; wait_strobe = 1'b0; nmi = 1'b0;
      chk(vtag[i], mode, VEC[i][9:8]);
      chk(vtag[i], hf_osc_en, VEC[i][7]);
      chk(vtag[i], pll_en, VEC[i][6]);
      chk(vtag[i], slow_clk_sel, VEC[i][5]);
      chk(vtag[i], ctl_rd, VEC[i][4:0]);
    end
    wait_act(2'd2);
    chk("R10 bits after wake", ctl_rd, 5'b10000);

    // R3: halt from Active, then ignored idle strobe, then NMI wake
    wr(5'b10100); strobe();
    chk("R3 halt mode", mode, 3);
    chk("R3 hf off", hf_osc_en, 0);
    chk("R3 pll off", pll_en, 0);
    chk("R10 halt bit cleared", ctl_rd, 5'b10000);
    wr(5'b10010); strobe();
    chk("R9 strobe in halt", mode, 3);
    pulse_nmi();
    chk("R7 pll still off", pll_en, 0);
    wait_act(2'd3);

    // R4: save blocked by lf status
    lf_stable = 1'b0;
    wr(5'b00001); cyc(3);
    chk("R4 save held off", mode, 0);
    lf_stable = 1'b1; cyc(1);
    chk("R4 save entered", mode, 1);
    chk("R5 slow in save", slow_clk_sel, 1);
    chk("R5 hf on in save", hf_osc_en, 1);
    chk("R8 save flag", ctl_rd, 5'b00001);
    wr(5'b01001); cyc(1);
    chk("R5 hf disabled in save", hf_osc_en, 0);
    wr(5'b01101); strobe();
    chk("R3 halt from save", mode, 3);
    chk("R10 rd in halt", ctl_rd, 5'b01000);
    wake_line = 1'b1; cyc(1); wake_line = 1'b0;
    wait_act(2'd3);
    chk("R10 rd after wake line", ctl_rd, 5'b01000);

    // R8: software exit
    wr(5'b00001); cyc(1);
    chk("R8 in save", mode, 1);
    wr(5'b00000);
    chk("R8 flag held", ctl_rd[0], 1);
    cyc(1);
    chk("R8 flag held in wake", ctl_rd[0], 1);
    wait_act(2'd1);
    chk("R8 flag cleared", ctl_rd[0], 0);

    // R4: gated save waits for strobe
    wr(5'b10001); cyc(3);
    chk("R4 gated save waits", mode, 0);
    strobe();
    chk("R4 gated save entered", mode, 1);
    pulse_nmi(); wait_act(2'd1);

    // R11: priority
    wr(5'b10111); strobe();
    chk("R11 halt wins", mode, 3);
    pulse_nmi(); wait_act(2'd3);
    wr(5'b10011); strobe();
    chk("R11 idle beats save", mode, 2);
    pulse_nmi(); wait_act(2'd2);

    // R5: idle with hf disabled, crystal present
    wr(5'b11010); strobe();
    chk("R5 idle mode", mode, 2);
    chk("R5 hf off in idle", hf_osc_en, 0);
    pulse_nmi(); wait_act(2'd2);

    // R6: no crystal
    lf_xtal_present = 1'b0; lf_stable = 1'b0;
    wr(5'b11010); strobe();
    chk("R6 idle without crystal", mode, 2);
    chk("R6 hf kept on", hf_osc_en, 1);
    pulse_nmi(); wait_act(2'd2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule